// File: doc/BRIEF.md
# Masked Lane-Wise Vector Unary Unit

This block applies one unary operation to every element of a 128-bit vector. It then writes the result back into a copy of the previous destination contents, one byte at a time. A 16-bit enable word gives one bit per byte of the vector. Bytes whose bit is set take the computed value, and bytes whose bit is clear keep the old destination byte. An element wider than a byte uses one enable bit per byte, so it can be written in part.

The operation set covers the following: counting leading zeros, counting redundant sign bits, reordering sub-fields inside 16/32/64-bit containers, bitwise inversion, wrapping integer absolute value and negation, and sign-bit clear or flip for floating-point lanes. The caller gives an operation code, an element-size code, the source, the old destination and the byte enables, together with a valid strobe. One clock edge later the merged vector appears on a registered output with a one-cycle done pulse. Some operation and size pairs are not supported. For those the block returns the old destination unchanged and raises an illegal flag.

Top module: `vec_unary_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `result` is all zeros and `done` and `illegal` are 0.
- R2: A cycle with `in_valid` high loads `result`, `done` and `illegal` at the next rising edge. `done` is high for exactly that one cycle, and `result` holds its value in any cycle that follows a cycle without `in_valid`.
- R3: Byte i of `result` (bits 8i+7..8i) equals byte i of the computed value when `byte_en[i]` is 1, and equals byte i of `old_dst` when it is 0. This applies to every element size.
- R4: Operation 0 (leading-zero count) works on element sizes 0, 1 and 2 (8, 16 and 32 bits). Each element becomes the number of zero bits above its highest set bit, which equals the element width for an all-zero element.
- R5: Operation 1 (sign count) works on sizes 0, 1 and 2. Each element becomes the number of bits below the sign bit that equal the sign bit before the first bit that differs, so 0 and all-ones give width minus one.
- R6: Operation 2 reverses bytes within containers of size 1, 2 or 3 (16, 32 or 64 bits). Operation 3 reverses halfwords within size 2 or 3. Operation 4 swaps the two words within size 3.
- R7: Operation 5 inverts all 128 bits and is legal for every size code.
- R8: Operation 6 (absolute value) and operation 7 (negation) treat elements of size 0, 1 or 2 as two's-complement. The most negative value maps to itself.
- R9: Operation 8 clears, and operation 9 inverts, the top bit of each 16-bit (size 1) or 32-bit (size 2) lane. All other bits are left alone.
- R10: Any operation and size pair not listed above, and operation codes 10 to 15, produce `result` equal to `old_dst` with `illegal` high alongside `done`. A legal pair gives `illegal` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Operation select (0 to 9 defined) |
| elem_size | input | 2 | Element or container size code: 0=8, 1=16, 2=32, 3=64 bits |
| src_vec | input | 128 | Source operand |
| old_dst | input | 128 | Previous destination contents |
| byte_en | input | 16 | Per-byte write enable |
| result | output | 128 | Merged destination, registered |
| done | output | 1 | One-cycle pulse when result updates |
| illegal | output | 1 | Unsupported operation and size pair |

## Verification
The bench aims at element boundaries. If the enable word is sliced per element instead of per byte, a half-enabled halfword or word comes back either fully written or fully kept. The most negative integers and the zero and all-ones inputs to the counters are driven directly. A carry that runs across lanes, or a count that is off by one, then shows up as a wrong low byte. Every illegal pair is also covered, so a decoder that lets an unsupported reversal or float size fall through changes bytes that should have stayed as the old destination.

// File: rtl/vun_pkg.sv
package vun_pkg;
  localparam int VEC_BYTES = 16;
  localparam int VEC_W     = VEC_BYTES * 8;

  typedef enum logic [3:0] {
    OP_CLZ  = 4'd0,
    OP_CLS  = 4'd1,
    OP_REVB = 4'd2,
    OP_REVH = 4'd3,
    OP_REVW = 4'd4,
    OP_NOT  = 4'd5,
    OP_ABS  = 4'd6,
    OP_NEG  = 4'd7,
    OP_FABS = 4'd8,
    OP_FNEG = 4'd9
  } vun_op_e;

  typedef enum logic [1:0] {
    AR_ABS  = 2'd0,
    AR_NEG  = 2'd1,
    AR_FABS = 2'd2,
    AR_FNEG = 2'd3
  } vun_arith_e;
endpackage

// File: rtl/vun_lead_count.sv
module vun_lead_count #(
  parameter int VEC_BYTES = 16,
  localparam int VEC_W = VEC_BYTES * 8
) (
  input  logic [VEC_W-1:0] src,
  input  logic [1:0]       size_sel,
  input  logic             sign_mode,
  output logic [VEC_W-1:0] cnt_out
);
  // leading zeros among the top n bits of a left-aligned 64-bit value
  function automatic logic [6:0] top_zeros(input logic [63:0] v, input int n);
    logic [6:0] c;
    logic       hit;
    c = '0;
    hit = 1'b0;
    for (int i = 0; i < 32; i++) begin
      if (i < n && !hit) begin
        if (v[63-i]) hit = 1'b1;
        else c = c + 7'd1;
      end
    end
    return c;
  endfunction

  for (genvar gs = 0; gs < 3; gs++) begin : g_sz
    localparam int EB = 1 << gs;
    localparam int EW = 8 * EB;
    localparam int NE = VEC_BYTES / EB;
    logic [VEC_W-1:0] res;
    for (genvar ge = 0; ge < NE; ge++) begin : g_el
      logic [EW-1:0] elem, pat;
      logic [63:0]   aligned;
      assign elem = src[ge*EW +: EW];
      // sign count: xor bits below the sign with it, then a stop bit
      assign pat = sign_mode ? {elem[EW-2:0] ^ {(EW-1){elem[EW-1]}}, 1'b1} : elem;
      assign aligned = 64'(pat) << (64 - EW);
      assign res[ge*EW +: EW] = EW'(top_zeros(aligned, EW));
    end
  end

  always_comb begin
    case (size_sel)
      2'd0:    cnt_out = g_sz[0].res;
      2'd1:    cnt_out = g_sz[1].res;
      default: cnt_out = g_sz[2].res;
    endcase
  end
endmodule

// File: rtl/vun_permute.sv
module vun_permute #(
  parameter int VEC_BYTES = 16,
  localparam int VEC_W = VEC_BYTES * 8,
  localparam int NVAR = 6
) (
  input  logic [VEC_W-1:0] src,
  input  logic [2:0]       rev_sel,
  output logic [VEC_W-1:0] perm_out
);
  logic [VEC_W-1:0] var_res [NVAR];

  // variant v: unit log2 bytes UL, container log2 bytes CL
  for (genvar v = 0; v < NVAR; v++) begin : g_var
    localparam int UL = (v < 3) ? 0 : ((v < 5) ? 1 : 2);
    localparam int CL = (v < 3) ? v + 1 : ((v < 5) ? v - 1 : 3);
    localparam int FLIP = (1 << (CL - UL)) - 1;
    for (genvar i = 0; i < VEC_BYTES; i++) begin : g_byte
      localparam int SRC_IDX = (((i >> UL) ^ FLIP) << UL) | (i & ((1 << UL) - 1));
      assign var_res[v][i*8 +: 8] = src[SRC_IDX*8 +: 8];
    end
  end

  always_comb begin
    perm_out = var_res[0];
    for (int k = 1; k < NVAR; k++)
      if (rev_sel == 3'(k)) perm_out = var_res[k];
  end
endmodule

// File: rtl/vun_lane_arith.sv
module vun_lane_arith
  import vun_pkg::*;
#(
  parameter int VEC_BYTES = 16,
  localparam int VEC_W = VEC_BYTES * 8
) (
  input  logic [VEC_W-1:0] src,
  input  logic [1:0]       size_sel,
  input  vun_arith_e       kind,
  output logic [VEC_W-1:0] arith_out
);
  for (genvar gs = 0; gs < 3; gs++) begin : g_sz
    localparam int EW = 8 << gs;
    localparam int NE = VEC_W / EW;
    logic [VEC_W-1:0] r_abs, r_neg, r_fab, r_fng;
    for (genvar ge = 0; ge < NE; ge++) begin : g_el
      logic [EW-1:0] elem, negv;
      assign elem = src[ge*EW +: EW];
      assign negv = (~elem) + EW'(1);
      assign r_neg[ge*EW +: EW] = negv;
      assign r_abs[ge*EW +: EW] = elem[EW-1] ? negv : elem;
      assign r_fab[ge*EW +: EW] = {1'b0, elem[EW-2:0]};
      assign r_fng[ge*EW +: EW] = {~elem[EW-1], elem[EW-2:0]};
    end
  end

  logic [VEC_W-1:0] pick [3];
  for (genvar gs = 0; gs < 3; gs++) begin : g_pick
    always_comb begin
      case (kind)
        AR_ABS:  pick[gs] = g_sz[gs].r_abs;
        AR_NEG:  pick[gs] = g_sz[gs].r_neg;
        AR_FABS: pick[gs] = g_sz[gs].r_fab;
        default: pick[gs] = g_sz[gs].r_fng;
      endcase
    end
  end

  always_comb begin
    case (size_sel)
      2'd0:    arith_out = pick[0];
      2'd1:    arith_out = pick[1];
      default: arith_out = pick[2];
    endcase
  end
endmodule

// File: rtl/vec_unary_unit.sv
module vec_unary_unit
  import vun_pkg::*;
#(
  parameter int NBYTES = 16,
  localparam int W = NBYTES * 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [3:0]    op_code,
  input  logic [1:0]    elem_size,
  input  logic [W-1:0]  src_vec,
  input  logic [W-1:0]  old_dst,
  input  logic [NBYTES-1:0] byte_en,
  output logic [W-1:0]  result,
  output logic          done,
  output logic          illegal
);
  logic [W-1:0] cnt_v, perm_v, ar_v, op_v, merged;
  logic [2:0]   rev_sel;
  vun_arith_e   ar_kind;
  logic         legal;

  vun_lead_count #(.VEC_BYTES(NBYTES)) u_cnt (
    .src(src_vec), .size_sel(elem_size), .sign_mode(op_code == OP_CLS), .cnt_out(cnt_v));

  vun_permute #(.VEC_BYTES(NBYTES)) u_perm (
    .src(src_vec), .rev_sel(rev_sel), .perm_out(perm_v));

  vun_lane_arith #(.VEC_BYTES(NBYTES)) u_ar (
    .src(src_vec), .size_sel(elem_size), .kind(ar_kind), .arith_out(ar_v));

  always_comb begin
    legal   = 1'b0;
    op_v    = old_dst;
    rev_sel = 3'd0;
    ar_kind = AR_ABS;
    case (op_code)
      OP_CLZ, OP_CLS: begin
        legal = (elem_size != 2'd3);
        op_v  = cnt_v;
      end
      OP_REVB: begin
        legal   = (elem_size != 2'd0);
        rev_sel = 3'(elem_size) - 3'd1;
        op_v    = perm_v;
      end
      OP_REVH: begin
        legal   = elem_size[1];
        rev_sel = 3'd3 + 3'(elem_size[0]);
        op_v    = perm_v;
      end
      OP_REVW: begin
        legal   = (elem_size == 2'd3);
        rev_sel = 3'd5;
        op_v    = perm_v;
      end
      OP_NOT: begin
        legal = 1'b1;
        op_v  = ~src_vec;
      end
      OP_ABS, OP_NEG: begin
        legal   = (elem_size != 2'd3);
        ar_kind = (op_code == OP_ABS) ? AR_ABS : AR_NEG;
        op_v    = ar_v;
      end
      OP_FABS, OP_FNEG: begin
        legal   = (elem_size == 2'd1) || (elem_size == 2'd2);
        ar_kind = (op_code == OP_FABS) ? AR_FABS : AR_FNEG;
        op_v    = ar_v;
      end
      default: legal = 1'b0;
    endcase
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_merge
    assign merged[i*8 +: 8] = (legal && byte_en[i]) ? op_v[i*8 +: 8] : old_dst[i*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result  <= '0;
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done <= in_valid;
      if (in_valid) begin
        result  <= merged;
        illegal <= !legal;
      end
    end
  end

  // R2: done only follows a strobe
  assert_done_follows_valid_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(in_valid) && !$past(rst)));

  // R2: result stable without a strobe
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(in_valid) && !$past(rst)) |-> $stable(result));

  // R10: illegal returns the old destination
  assert_illegal_keeps_R10: assert property (@(posedge clk) disable iff (rst)
    (illegal && done) |-> (result == $past(old_dst)));

  // R1: outputs cleared the cycle after reset
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (!done && !illegal && result == '0));

  // R3: disabled bytes keep the old destination
  for (genvar i = 0; i < NBYTES; i++) begin : g_chk
    assert_masked_byte_R3: assert property (@(posedge clk) disable iff (rst)
      (done && !$past(byte_en[i])) |-> (result[i*8 +: 8] == $past(old_dst[i*8 +: 8])));
  end
endmodule

// File: tb/test_vec_unary_unit.sv
module test_vec_unary_unit;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [3:0]   op_code = '0;
  logic [1:0]   elem_size = '0;
  logic [127:0] src_vec = '0, old_dst = '0;
  logic [15:0]  byte_en = '0;
  logic [127:0] result;
  logic         done, illegal;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  vec_unary_unit i_vec_unary_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code), .elem_size(elem_size),
    .src_vec(src_vec), .old_dst(old_dst), .byte_en(byte_en),
    .result(result), .done(done), .illegal(illegal));

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0: return "R4";
      4'd1: return "R5";
      4'd2, 4'd3, 4'd4: return "R6";
      4'd5: return "R7";
      4'd6, 4'd7: return "R8";
      4'd8, 4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic bit is_legal(input logic [3:0] op, input logic [1:0] sz);
    case (op)
      4'd0, 4'd1, 4'd6, 4'd7: return sz <= 2;
      4'd2: return sz >= 1;
      4'd3: return sz >= 2;
      4'd4: return sz == 3;
      4'd5: return 1;
      4'd8, 4'd9: return sz == 1 || sz == 2;
      default: return 0;
    endcase
  endfunction

  function automatic logic [127:0] ref_calc(input logic [3:0] op, input logic [1:0] sz, input logic [127:0] s);
    int eb, ew, u;
    logic [127:0] r;
    logic [63:0] x, y, m;
    eb = 1 << sz;
    ew = 8 * eb;
    r = '0;
    if (op >= 2 && op <= 4) begin
      u = (op == 2) ? 1 : ((op == 3) ? 2 : 4);
      for (int i = 0; i < 16; i++)
        r[i*8 +: 8] = s[((((i / u) ^ (eb / u - 1)) * u) + (i % u)) * 8 +: 8];
    end else if (op == 5) begin
      r = ~s;
    end else begin
      m = (64'd1 << ew) - 64'd1;
      for (int e = 0; e < 16 / eb; e++) begin
        x = 64'(s >> (e * ew)) & m;
        y = 0;
        case (op)
          4'd0: begin
            for (int b = ew - 1; b >= 0; b--) begin
              if (x[b]) break;
              y++;
            end
          end
          4'd1: begin
            for (int b = ew - 2; b >= 0; b--) begin
              if (x[b] != x[ew-1]) break;
              y++;
            end
          end
          4'd6: y = x[ew-1] ? (64'd0 - x) : x;
          4'd7: y = 64'd0 - x;
          4'd8: y = x & ~(64'd1 << (ew - 1));
          default: y = x ^ (64'd1 << (ew - 1));
        endcase
        r = r | (128'(y & m) << (e * ew));
      end
    end
    return r;
  endfunction

  task automatic run(input logic [3:0] op, input logic [1:0] sz, input logic [127:0] s,
                     input logic [127:0] od, input logic [15:0] en);
    logic [127:0] exp, calc, held;
    bit lg;
    string rq;
    lg = is_legal(op, sz);
    calc = lg ? ref_calc(op, sz, s) : '0;
    for (int i = 0; i < 16; i++)
      exp[i*8 +: 8] = (lg && en[i]) ? calc[i*8 +: 8] : od[i*8 +: 8];
    rq = req_of(op);
    if (!lg) rq = "R10";
    @(negedge clk);
    in_valid = 1'b1; op_code = op; elem_size = sz; src_vec = s; old_dst = od; byte_en = en;
    @(negedge clk);
    in_valid = 1'b0;
    src_vec = ~s; old_dst = ~od;
    check(result == exp, (en == 16'hFFFF || !lg) ? rq : {rq, "/R3"}, result, exp);
    check(done == 1'b1, "R2", 128'(done), 128'd1);
    check(illegal == !lg, "R10", 128'(illegal), 128'(!lg));
    held = result;
    @(negedge clk);
    check(done == 1'b0 && result == held, "R2", result, held);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    // R1: reset clears outputs even with a strobe held
    in_valid = 1'b1; src_vec = '1; old_dst = '1; byte_en = '1;
    @(negedge clk);
    check(result == '0, "R1", result, '0);
    check(done == 1'b0 && illegal == 1'b0, "R1", {done, illegal}, 0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check(result == '0 && !done && !illegal, "R1", result, '0);

    // directed corner cases
    run(4'd0, 2'd0, '0, 128'h1111, 16'hFFFF);                              // R4 zero bytes -> 8
    run(4'd0, 2'd2, {32'h1, 32'h8000_0000, 32'h0, 32'h0001_0000}, '0, 16'hFFFF); // R4 words
    run(4'd1, 2'd0, {64'hFF00_7F80_4001_C0FF, 64'h0}, '0, 16'hFFFF);       // R5 bytes
    run(4'd1, 2'd1, {16'hFFFF, 16'h0000, 16'h0001, 16'hFFFE, 64'h8000_4000_3FFF_C000}, '0, 16'hFFFF); // R5 halves
    run(4'd6, 2'd0, {16{8'h80}}, '0, 16'hFFFF);                            // R8 wrap byte
    run(4'd7, 2'd2, {4{32'h8000_0000}}, '0, 16'hFFFF);                     // R8 wrap word
    run(4'd6, 2'd1, {8{16'hFFFF}}, '1, 16'b0101_0101_0101_0101);           // R3 partial halves
    run(4'd7, 2'd2, {4{32'h0000_0001}}, '0, 16'b0011_0110_1100_0001);      // R3 partial words
    run(4'd2, 2'd3, 128'h0f0e0d0c0b0a09080706050403020100, '0, 16'hFFFF);  // R6
    run(4'd3, 2'd2, 128'h0f0e0d0c0b0a09080706050403020100, '0, 16'hFFFF);  // R6
    run(4'd4, 2'd3, 128'h0f0e0d0c0b0a09080706050403020100, '0, 16'hFFFF);  // R6
    run(4'd5, 2'd0, 128'h0123_4567_89ab_cdef_0000_ffff_a5a5_5a5a, '0, 16'hF0F0); // R7
    run(4'd8, 2'd1, '1, '0, 16'hFFFF);                                     // R9
    run(4'd9, 2'd2, '0, '1, 16'h0FF0);                                     // R9
    run(4'd7, 2'd1, {8{16'h1234}}, '1, 16'h0000);                          // R3 all disabled
    run(4'd2, 2'd0, 128'h1, 128'hdead_beef, 16'hFFFF);                     // R10
    run(4'd3, 2'd1, 128'h1, 128'hcafe, 16'hFFFF);                          // R10
    run(4'd4, 2'd2, 128'h1, 128'hbeef, 16'hFFFF);                          // R10
    run(4'd8, 2'd0, 128'h1, 128'h77, 16'hFFFF);                            // R10
    run(4'd9, 2'd3, 128'h1, 128'h78, 16'hFFFF);                            // R10
    run(4'd0, 2'd3, 128'h1, 128'h79, 16'hFFFF);                            // R10
    run(4'd12, 2'd1, 128'h1, 128'h7a, 16'hFFFF);                           // R10

    // random mix
    for (int k = 0; k < 600; k++) begin
      logic [127:0] s, od;
      logic [15:0] en;
      logic [3:0] op;
      s  = {$urandom, $urandom, $urandom, $urandom};
      od = {$urandom, $urandom, $urandom, $urandom};
      en = 16'($urandom);
      if (k % 5 == 0) en = 16'hFFFF;
      if (k % 7 == 0) s = s >> (($urandom % 4) * 32 + ($urandom % 31));
      op = ($urandom % 8 == 0) ? 4'($urandom) : 4'($urandom % 10);
      run(op, 2'($urandom), s, od, en);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    finished = 1;
    $finish;
  end
endmodule